// File: doc/BRIEF.md
# Interval and Free-Run Timer Channel

A single channel of a 32-bit operating-system tick timer on a simple register bus. Software writes a compare value and a control byte. It then starts the channel with a write-1 pulse to a start register and halts it with a write-1 pulse to a separate stop register. A read-only status register shows whether the counter is running, and software polls it after a stop before it reprograms the channel.

Two modes exist. In interval mode the channel loads the compare value, counts down, and raises a one-clock interrupt and reloads every compare+1 clocks. In free-run mode the channel counts up from zero, wraps at the counter width, and raises a one-clock interrupt whenever the count equals the compare value. Compare and control writes made while the channel runs are held until the next start. The live count can be read at any time.

Top module: `os_tick_timer`

## Requirements
- R1: After reset the compare, counter, status and control registers all read 0 and `irqPulse` is low.
- R2: Offset 0x00 is a read/write compare register and offset 0x20 a read/write 8-bit control register. Offsets 0x14, 0x18 and any unmapped offset read as 0.
- R3: A write to offset 0x14 with bit 0 set makes status bit 0 (offset 0x10) read 1 from the next cycle. The same write with bit 0 clear has no effect.
- R4: A write to offset 0x18 with bit 0 set makes status bit 0 read 0 from the next cycle, and the count then holds its value.
- R5: With control bit 1 at 0 (interval), start loads the compare value N into the counter, which then counts down. `irqPulse` is high for one cycle N+1 cycles after the start edge and every N+1 cycles after that, and the counter reloads N.
- R6: With control bit 1 at 1 (free run), start clears the counter, which then counts up by one per cycle and wraps from its all-ones value to 0.
- R7: In free-run mode `irqPulse` is high for the one cycle after the count equals the compare value, and counting continues through the match.
- R8: Compare and control writes while the channel runs change the register read-back at once but change the count and interrupt pattern only at the next start.
- R9: A start write while the channel runs restarts the count from its initial value for the mode.
- R10: Offset 0x04 returns the live count on every cycle, running or stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 6 | Byte offset for both read and write |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for `busAddr` |
| irqPulse | output | 1 | One-cycle interrupt pulse |

## Verification
Register writes take effect at the edge that samples them, so read-back, status and count changes appear in the cycle after the write edge, while reads are combinational on the current offset. An interval interrupt appears in the cycle after edge start+N+1 and a free-run interrupt in the cycle after edge start+compare+1. The bench drives just after each rising edge, samples at the falling edge, and compares the read data and interrupt against a behavioural model every cycle. Directed checks count interrupt pulses over 64-cycle windows anchored on the start edge and read the counter at exact offsets from it, with a narrow instance showing the wrap.

// File: rtl/os_tick_timer_pkg.sv
`timescale 1ns/1ps
package os_tick_timer_pkg;
  localparam int ADDR_W = 6;
  localparam int BUS_W  = 32;
  localparam int CTL_W  = 8;
  localparam int MODE_BIT = 1;

  localparam logic [ADDR_W-1:0] OFS_CMP    = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_START  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_STOP   = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_CTL    = 6'h20;

  typedef enum logic {
    MODE_INTERVAL = 1'b0,
    MODE_FREERUN  = 1'b1
  } tmr_mode_e;

  // Per-cycle counter commands from control to datapath; at most one is set.
  typedef struct packed {
    logic loadDown;  // start, interval: count <= compare, capture compare
    logic clearUp;   // start, free run: count <= 0, capture compare
    logic reload;    // interval terminal: count <= captured compare
    logic decr;      // interval step
    logic incr;      // free-run step
  } tmr_strobe_t;
endpackage

// File: rtl/os_tick_timer_dp.sv
`timescale 1ns/1ps
module os_tick_timer_dp
  import os_tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmr_strobe_t      stb,
  input  logic [CNT_W-1:0] cmpReg,
  output logic [CNT_W-1:0] cntVal,
  output logic             cntZero,
  output logic             cntMatch
);
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] heldCmp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      heldCmp <= '0;
    end else if (stb.loadDown) begin
      cntQ    <= cmpReg;
      heldCmp <= cmpReg;
    end else if (stb.clearUp) begin
      cntQ    <= '0;
      heldCmp <= cmpReg;
    end else if (stb.reload) begin
      cntQ <= heldCmp;
    end else if (stb.decr) begin
      cntQ <= cntQ - 1'b1;
    end else if (stb.incr) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign cntVal   = cntQ;
  assign cntZero  = (cntQ == '0);
  assign cntMatch = (cntQ == heldCmp);

  // R5
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));
  // R6
  up_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.incr |=> cntQ == $past(cntQ) + 1'b1);
  // R5
  down_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.decr |=> cntQ == $past(cntQ) - 1'b1);
  // R6
  clear_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearUp |=> cntQ == '0);
  // R4
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb == '0) |=> $stable(cntQ));
endmodule

// File: rtl/os_tick_timer_ctrl.sv
`timescale 1ns/1ps
module os_tick_timer_ctrl
  import os_tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [BUS_W-1:0]  busRdData,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              cntZero,
  input  logic              cntMatch,
  output tmr_strobe_t       stb,
  output logic [CNT_W-1:0]  cmpReg,
  output logic              irqPulse
);
  logic [CTL_W-1:0] ctlReg;
  logic             running;
  tmr_mode_e        activeMode;
  logic             startStb;
  logic             stopStb;
  logic             irqQ;

  assign startStb = busWrEn && (busAddr == OFS_START) && busWrData[0];
  assign stopStb  = busWrEn && (busAddr == OFS_STOP)  && busWrData[0];

  // Software-visible registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpReg <= '0;
      ctlReg <= '0;
    end else if (busWrEn) begin
      if (busAddr == OFS_CMP) cmpReg <= busWrData[CNT_W-1:0];
      if (busAddr == OFS_CTL) ctlReg <= busWrData[CTL_W-1:0];
    end
  end

  // Run state, mode captured at start, registered interrupt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running    <= 1'b0;
      activeMode <= MODE_INTERVAL;
      irqQ       <= 1'b0;
    end else if (startStb) begin
      running    <= 1'b1;
      activeMode <= tmr_mode_e'(ctlReg[MODE_BIT]);
      irqQ       <= 1'b0;
    end else if (stopStb) begin
      running <= 1'b0;
      irqQ    <= 1'b0;
    end else begin
      irqQ <= running && ((activeMode == MODE_FREERUN) ? cntMatch : cntZero);
    end
  end

  always_comb begin
    stb = '0;
    if (startStb) begin
      if (ctlReg[MODE_BIT]) stb.clearUp  = 1'b1;
      else                  stb.loadDown = 1'b1;
    end else if (running && !stopStb) begin
      if (activeMode == MODE_FREERUN) stb.incr   = 1'b1;
      else if (cntZero)               stb.reload = 1'b1;
      else                            stb.decr   = 1'b1;
    end
  end

  always_comb begin
    case (busAddr)
      OFS_CMP:    busRdData = BUS_W'(cmpReg);
      OFS_COUNT:  busRdData = BUS_W'(cntVal);
      OFS_STATUS: busRdData = BUS_W'(running);
      OFS_CTL:    busRdData = BUS_W'(ctlReg);
      default:    busRdData = '0;
    endcase
  end

  assign irqPulse = irqQ;

  // R3
  start_sets_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> running);
  // R4
  stop_clears_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopStb |=> !running);
  // R5
  irq_needs_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(running));
  // R8
  mode_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && !startStb) |=> $stable(activeMode));
endmodule

// File: rtl/os_tick_timer.sv
`timescale 1ns/1ps
module os_tick_timer
  import os_tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [BUS_W-1:0]  busRdData,
  output logic              irqPulse
);
  tmr_strobe_t      stb;
  logic [CNT_W-1:0] cmpReg;
  logic [CNT_W-1:0] cntVal;
  logic             cntZero;
  logic             cntMatch;

  os_tick_timer_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData),
    .cntVal(cntVal), .cntZero(cntZero), .cntMatch(cntMatch),
    .stb(stb), .cmpReg(cmpReg), .irqPulse(irqPulse)
  );

  os_tick_timer_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN),
    .stb(stb), .cmpReg(cmpReg),
    .cntVal(cntVal), .cntZero(cntZero), .cntMatch(cntMatch)
  );
endmodule

// File: tb/os_tick_timer_tb_top.sv
`timescale 1ns/1ps
module os_tick_timer_ref #(
  parameter int W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [5:0]  addr,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic [31:0] rd,
  output logic        irq
);
  longint unsigned mask;
  longint unsigned cmpV, ctlV, cntV, heldV;
  bit runV, freeV;
  assign mask = (W >= 64) ? '1 : ((64'd1 << W) - 1);

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpV <= 0; ctlV <= 0; cntV <= 0; heldV <= 0;
      runV <= 0; freeV <= 0; irq <= 0;
    end else begin
      bit goNow, haltNow;
      goNow   = wr && addr == 6'h14 && wdata[0];
      haltNow = wr && addr == 6'h18 && wdata[0];
      if (wr && addr == 6'h00) cmpV <= wdata & mask;
      if (wr && addr == 6'h20) ctlV <= wdata & 32'hFF;
      if (goNow) begin
        runV  <= 1;
        freeV <= ctlV[1];
        heldV <= cmpV;
        cntV  <= ctlV[1] ? 0 : cmpV;
        irq   <= 0;
      end else if (haltNow) begin
        runV <= 0;
        irq  <= 0;
      end else if (!runV) begin
        irq <= 0;
      end else if (freeV) begin
        irq  <= (cntV == heldV);
        cntV <= (cntV + 1) & mask;
      end else if (cntV == 0) begin
        irq  <= 1;
        cntV <= heldV;
      end else begin
        irq  <= 0;
        cntV <= cntV - 1;
      end
    end
  end

  always_comb begin
    case (addr)
      6'h00:   rd = cmpV[31:0];
      6'h04:   rd = cntV[31:0];
      6'h10:   rd = {31'd0, runV};
      6'h20:   rd = ctlV[31:0];
      default: rd = 32'd0;
    endcase
  end
endmodule

module os_tick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = 6'h04;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] rdA, rdB, mRdA, mRdB;
  logic        irqA, irqB, mIrqA, mIrqB;

  int    checks = 0;
  int    fails  = 0;
  int    irqCntA = 0;
  int    irqCntB = 0;
  bit    done = 0;
  string phaseReq = "R1";

  always #2.5 clk = ~clk;

  os_tick_timer dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(rdA), .irqPulse(irqA));
  os_tick_timer #(.CNT_W(8)) dut_narrow_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(rdB), .irqPulse(irqB));

  os_tick_timer_ref #(.W(32)) refA (
    .clk(clk), .rstN(rstN), .addr(busAddr), .wr(busWrEn),
    .wdata(busWrData), .rd(mRdA), .irq(mIrqA));
  os_tick_timer_ref #(.W(8)) refB (
    .clk(clk), .rstN(rstN), .addr(busAddr), .wr(busWrEn),
    .wdata(busWrData), .rd(mRdB), .irq(mIrqB));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model, plus pulse counters
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk({phaseReq, " rdA"}, rdA, mRdA);
      chk({phaseReq, " irqA"}, {31'd0, irqA}, {31'd0, mIrqA});
      chk({phaseReq, " rdB"}, rdB, mRdB);
      chk({phaseReq, " irqB"}, {31'd0, irqB}, {31'd0, mIrqB});
      if (irqA) irqCntA++;
      if (irqB) irqCntB++;
    end
  end

  task automatic wrReg(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busAddr = a; busWrEn = 1'b1; busWrData = d;
    @(posedge clk); #1;
    busWrEn = 1'b0; busAddr = 6'h04;
  endtask

  task automatic rdChk(input string req, input logic [5:0] a, input logic [31:0] exp);
    @(posedge clk); #1;
    busAddr = a;
    @(negedge clk);
    chk(req, rdA, exp);
    #1 busAddr = 6'h04;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [31:0] held;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {31'd0, irqA}, 32'd0);
    chk("R1 count in reset", rdA, 32'd0);
    #1 rstN = 1'b1;
    rdChk("R1 compare", 6'h00, 32'd0);
    rdChk("R1 status", 6'h10, 32'd0);
    rdChk("R1 control", 6'h20, 32'd0);

    // R2: read/write registers and write-only offsets
    phaseReq = "R2";
    wrReg(6'h00, 32'h1234_5678);
    rdChk("R2 compare readback", 6'h00, 32'h1234_5678);
    wrReg(6'h20, 32'h0000_00A5);
    rdChk("R2 control readback", 6'h20, 32'hA5);
    rdChk("R2 start reads 0", 6'h14, 32'd0);
    rdChk("R2 stop reads 0", 6'h18, 32'd0);
    rdChk("R2 unmapped reads 0", 6'h08, 32'd0);

    // R3: start with bit 0 clear does nothing
    phaseReq = "R3";
    wrReg(6'h20, 32'h0);
    wrReg(6'h00, 32'h0000_000F);
    wrReg(6'h14, 32'h0000_00FE);
    rdChk("R3 ignored start status", 6'h10, 32'd0);
    rdChk("R3 ignored start count", 6'h04, 32'd0);

    // R5: interval N=15, three pulses in 64 cycles
    phaseReq = "R5";
    wrReg(6'h14, 32'h1);
    irqCntA = 0;
    repeat (64) @(posedge clk);
    chk("R5 interval pulse count", irqCntA, 32'd3);
    rdChk("R3 status running", 6'h10, 32'd1);

    // R8: compare/control writes while running deferred
    phaseReq = "R8";
    wrReg(6'h14, 32'h1);
    irqCntA = 0;
    wrReg(6'h00, 32'h0000_0040);
    wrReg(6'h20, 32'h0000_0002);
    repeat (60) @(posedge clk);
    chk("R8 pattern unchanged", irqCntA, 32'd3);
    rdChk("R8 compare readback", 6'h00, 32'h40);

    // R9: restart while running (interval, N=15)
    phaseReq = "R9";
    wrReg(6'h20, 32'h0);
    wrReg(6'h00, 32'h0000_000F);
    wrReg(6'h14, 32'h1);
    repeat (8) @(posedge clk);
    wrReg(6'h14, 32'h1);
    irqCntA = 0;
    repeat (64) @(posedge clk);
    chk("R9 restart realigns pulses", irqCntA, 32'd3);

    // R4: stop clears status next cycle, count holds
    phaseReq = "R4";
    wrReg(6'h18, 32'h1);
    rdChk("R4 status cleared", 6'h10, 32'd0);
    @(negedge clk);
    held = rdA;
    repeat (5) @(negedge clk);
    chk("R4 count holds", rdA, held);

    // R7/R10: free run, compare 0x30, one match in 64 cycles
    phaseReq = "R7";
    wrReg(6'h20, 32'h2);
    wrReg(6'h00, 32'h30);
    wrReg(6'h14, 32'h1);
    irqCntA = 0; irqCntB = 0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R10 live count", rdA, 32'd20);
    repeat (44) @(posedge clk);
    chk("R7 match pulse", irqCntA, 32'd1);
    chk("R7 match pulse narrow", irqCntB, 32'd1);
    wrReg(6'h18, 32'h1);

    // R6: wrap in the narrow instance (free run, compare 0)
    phaseReq = "R6";
    wrReg(6'h00, 32'h0);
    wrReg(6'h14, 32'h1);
    repeat (255) @(posedge clk);
    @(negedge clk);
    chk("R6 narrow at all-ones", rdB, 32'hFF);
    chk("R6 wide counting up", rdA, 32'd255);
    @(negedge clk);
    chk("R6 narrow wrapped", rdB, 32'h0);
    chk("R6 wide continues", rdA, 32'd256);
    repeat (300) @(posedge clk);

    // R5/R10: largest compare in interval mode
    phaseReq = "R5";
    wrReg(6'h20, 32'h0);
    wrReg(6'h00, 32'hFFFF_FFFF);
    wrReg(6'h14, 32'h1);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R10 large compare count", rdA, 32'hFFFF_FFF5);
    wrReg(6'h18, 32'h1);

    // R5: interval N=1 pulses every other cycle
    wrReg(6'h00, 32'h1);
    wrReg(6'h14, 32'h1);
    irqCntA = 0;
    repeat (20) @(posedge clk);
    chk("R5 short period", irqCntA, 32'd9);
    wrReg(6'h18, 32'h1);
    repeat (4) @(posedge clk);

    finishRun();
  end
endmodule